// File: doc/BRIEF.md
# Bank-Switching Address Translation Unit

This block sits on the address bus of an 8-bit processor with a 16-bit logical address and widens it to a 19-bit physical address (512 KB). The logical space is split three ways. The top 24 KB (0xA000–0xFFFF) is a fixed region that passes straight through. An 8 KB firmware window (0x8000–0x9FFF) shows one of 16 pages of a 128 KB EPROM. A 32 KB RAM window (0x0000–0x7FFF) shows one of 8 maps of a 256 KB RAM. Translation and chip-select decoding are combinational, so a mapped access takes no more time than an unmapped one.

Two write-only control registers choose the firmware page and the RAM map. They sit in base-page RAM, and a write to them also reaches that RAM. Software therefore reads the current page and map numbers back from memory. The RAM register also sets the size of a common area at the bottom of the RAM window. Every map shares this area, so pointers and parameters that all maps need can live there. The interrupt vectors at the top of the logical space always fall in the fixed region.

Physical layout: RAM at 0x00000–0x3FFFF, EPROM at 0x40000–0x5FFFF, and the fixed region at 0x7A000–0x7FFFF, which is the 16-bit logical address with 3'b111 placed above it.

Top module: `bank_xlate`

## Requirements
- R1: After a synchronous active-low reset, the firmware page, the RAM map and the common size are all 0. In this state logical 0x8000 translates to 0x40000 and logical 0x1234 translates to 0x01234.
- R2: While `bus_valid` is high, exactly one chip select is high: `sel_ram` for 0x0000–0x7FFF, `sel_rom` for 0x8000–0x9FFF and `sel_fixed` for 0xA000–0xFFFF. While `bus_valid` is low, all chip selects are low.
- R3: In the fixed region, `phys_addr` equals {3'b111, logical address}.
- R4: In the firmware window, `phys_addr` equals {2'b10, page[3:0], addr[12:0]}. A valid write to any of 0x0004–0x0007 loads `bus_wdata[3:0]` into the page. The new page is in use from the next cycle.
- R5: In the RAM window, outside the common area, `phys_addr` equals {1'b0, map[2:0], addr[14:0]}. A valid write to any of 0x0008–0x000B loads `bus_wdata[2:0]` into the map. The new map is in use from the next cycle.
- R6: The same write also loads `bus_wdata[6:4]` into the common size N, counted in KB. A RAM-window address with addr[14:10] < N uses map 0 whatever map is selected.
- R7: Writing the firmware page register leaves the RAM map and the common size unchanged. Writing the RAM map register leaves the firmware page unchanged.
- R8: An access to a register address, whether a read or a write, is also a normal RAM access. `sel_ram` is high and `phys_addr` follows R5/R6 using the settings in force before the write.
- R9: Logical addresses 0xFFF0–0xFFFF (the vectors) always assert `sel_fixed` with a pass-through address, whatever the register settings.
- R10: Reads, writes outside 0x0004–0x000B, and writes with `bus_valid` low change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus cycle in progress |
| bus_we | input | 1 | Bus cycle is a write |
| bus_addr | input | 16 | Logical address |
| bus_wdata | input | 8 | Write data |
| phys_addr | output | 19 | Translated physical address |
| sel_fixed | output | 1 | Chip select, fixed region |
| sel_rom | output | 1 | Chip select, firmware EPROM |
| sel_ram | output | 1 | Chip select, RAM |

## Verification
The boundary addresses of each window (0x7FFF/0x8000, 0x9FFF/0xA000, 0xFFFF) are accessed under different register settings. These show whether the region decode and the pass-through are correct.

Every firmware page and every RAM map is written and then read back through translation. A wrong bit field in either register shows up as a wrong physical address.

For the common area, the common size is set to 0, 3 and 7 KB, and the addresses just below and just above each limit are accessed. This catches an off-by-one in the limit comparison.

Several kinds of stimulus must leave the registers unchanged: reads of the register addresses, writes just outside 0x0004–0x000B, writes with `bus_valid` low, and writes to one register followed by accesses through the other. Each is followed by translated accesses that reveal the register contents.

// File: rtl/bank_xlate_pkg.sv
// Shared constants and types for the bank-switching address translator.
// Assumes a 16-bit logical bus and a 19-bit physical bus with the layout
// given in the brief.
package bank_xlate_pkg;
    localparam int LA_W      = 16;   // logical address width
    localparam int PA_W      = 19;   // physical address width
    localparam int D_W       = 8;    // data bus width
    localparam int PAGE_W    = 4;    // firmware page number width
    localparam int MAP_W     = 3;    // RAM map number width
    localparam int CMN_W     = 3;    // common area size field width
    localparam int ROM_OFS_W = 13;   // 8 KB firmware window
    localparam int RAM_OFS_W = 15;   // 32 KB RAM window
    localparam int KB_W      = 10;   // 1 KB granule

    // Logical region boundaries
    localparam logic [LA_W-1:0] ROM_LO   = 16'h8000;
    localparam logic [LA_W-1:0] FIXED_LO = 16'hA000;

    // Register addresses, four-byte aligned blocks
    localparam logic [LA_W-1:0] PAGE_REG_BASE = 16'h0004;
    localparam logic [LA_W-1:0] MAP_REG_BASE  = 16'h0008;

    // Physical tags placed above each region's offset
    localparam int ROM_TAG_W   = PA_W - PAGE_W - ROM_OFS_W;
    localparam int FIXED_TAG_W = PA_W - LA_W;
    localparam logic [ROM_TAG_W-1:0]   ROM_TAG   = 2'b10;
    localparam logic [FIXED_TAG_W-1:0] FIXED_TAG = 3'b111;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_RAM   = 2'd1,
        RGN_ROM   = 2'd2,
        RGN_FIXED = 2'd3
    } region_e;
endpackage

// File: rtl/xlate_map_regs.sv
// Write-only map registers: firmware page, RAM map and common-area size.
// Assumes the caller qualifies wr_en with a valid bus write. The RAM
// below the registers is written by the same cycle outside this module.
module xlate_map_regs
    import bank_xlate_pkg::*;
#(
    parameter int AW = LA_W,
    parameter int DW = D_W,
    parameter int PW = PAGE_W,
    parameter int MW = MAP_W,
    parameter int CW = CMN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [PW-1:0] page,
    output logic [MW-1:0] map,
    output logic [CW-1:0] cmn_kb
);
    localparam int BLK_LSB = 2;   // each register answers on four addresses
    localparam int CMN_LSB = 4;   // common size field position in write data

    logic page_hit, map_hit;
    logic unused_wdata;

    // Address match for each register block
    always_comb begin
        page_hit = addr[AW-1:BLK_LSB] == PAGE_REG_BASE[AW-1:BLK_LSB];
        map_hit  = addr[AW-1:BLK_LSB] == MAP_REG_BASE[AW-1:BLK_LSB];
    end

    assign unused_wdata = ^{wdata[DW-1], wdata[MW]};

    // Firmware page register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (wr_en && page_hit)
            page <= wdata[PW-1:0];
    end

    // RAM map and common size register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map    <= '0;
            cmn_kb <= '0;
        end else if (wr_en && map_hit) begin
            map    <= wdata[MW-1:0];
            cmn_kb <= wdata[CMN_LSB +: CW];
        end
    end

    // R4
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && page_hit) |=> page == $past(wdata[PW-1:0]));
    // R6
    cmn_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && map_hit) |=> cmn_kb == $past(wdata[CMN_LSB +: CW]));
    // R7
    page_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && page_hit) |=> ($stable(map) && $stable(cmn_kb)));
    // R10
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(page) && $stable(map) && $stable(cmn_kb)));
endmodule

// File: rtl/xlate_region_decode.sv
// Splits the logical space into RAM, firmware and fixed regions and
// drives one chip select per region. Purely combinational.
module xlate_region_decode
    import bank_xlate_pkg::*;
#(
    parameter int AW = LA_W
) (
    input  logic          valid,
    input  logic [AW-1:0] addr,
    output region_e       region,
    output logic          sel_ram,
    output logic          sel_rom,
    output logic          sel_fixed
);
    // Region choice by address comparison against the window limits
    always_comb begin
        if (!valid)                 region = RGN_NONE;
        else if (addr >= FIXED_LO)  region = RGN_FIXED;
        else if (addr >= ROM_LO)    region = RGN_ROM;
        else                        region = RGN_RAM;
    end

    // One strobe per region
    always_comb begin
        sel_ram   = region == RGN_RAM;
        sel_rom   = region == RGN_ROM;
        sel_fixed = region == RGN_FIXED;
    end
endmodule

// File: rtl/xlate_addr_compose.sv
// Builds the physical address from the logical address and the current
// map settings. The fixed region passes through. The firmware window takes
// the page number. The RAM window takes the map number, except inside
// the common area, which always uses map 0.
module xlate_addr_compose
    import bank_xlate_pkg::*;
#(
    parameter int AW = LA_W,
    parameter int PA = PA_W,
    parameter int PW = PAGE_W,
    parameter int MW = MAP_W,
    parameter int CW = CMN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  region_e       region,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] page,
    input  logic [MW-1:0] map,
    input  logic [CW-1:0] cmn_kb,
    output logic [PA-1:0] phys
);
    localparam int KBIDX_W = RAM_OFS_W - KB_W;   // KB index inside RAM window
    localparam int RAM_PAD = PA - MW - RAM_OFS_W;

    logic [KBIDX_W-1:0] kb_idx;
    logic               in_common;
    logic [MW-1:0]      eff_map;

    // Common-area test: KB index of the access against the configured size
    always_comb begin
        kb_idx    = addr[RAM_OFS_W-1:KB_W];
        in_common = kb_idx < KBIDX_W'(cmn_kb);
        eff_map   = in_common ? '0 : map;
    end

    // Physical address per region
    always_comb begin
        unique case (region)
            RGN_FIXED: phys = {FIXED_TAG, addr};
            RGN_ROM:   phys = {ROM_TAG, page, addr[ROM_OFS_W-1:0]};
            default:   phys = {{RAM_PAD{1'b0}}, eff_map, addr[RAM_OFS_W-1:0]};
        endcase
    end

    // R3
    fixed_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_FIXED) |-> (phys[AW-1:0] == addr && phys[PA-1:AW] == FIXED_TAG));
    // R6
    common_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_RAM && addr[RAM_OFS_W-1:KB_W] < KBIDX_W'(cmn_kb))
            |-> phys[PA-1:RAM_OFS_W] == '0);
endmodule

// File: rtl/bank_xlate.sv
// Top level of the bank-switching address translator. Assumes the bus
// presents a stable address while bus_valid is high. The map registers
// change at the clock edge that ends a write cycle, so the write itself
// is translated with the old settings.
module bank_xlate
    import bank_xlate_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic            bus_we,
    input  logic [LA_W-1:0] bus_addr,
    input  logic [D_W-1:0]  bus_wdata,
    output logic [PA_W-1:0] phys_addr,
    output logic            sel_fixed,
    output logic            sel_rom,
    output logic            sel_ram
);
    region_e             region;
    logic [PAGE_W-1:0]   page;
    logic [MAP_W-1:0]    map;
    logic [CMN_W-1:0]    cmn_kb;
    logic                wr_en;

    // Qualified register write strobe
    assign wr_en = bus_valid && bus_we;

    xlate_map_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .page   (page),
        .map    (map),
        .cmn_kb (cmn_kb)
    );

    xlate_region_decode u_dec (
        .valid     (bus_valid),
        .addr      (bus_addr),
        .region    (region),
        .sel_ram   (sel_ram),
        .sel_rom   (sel_rom),
        .sel_fixed (sel_fixed)
    );

    xlate_addr_compose u_comp (
        .clk    (clk),
        .rst_n  (rst_n),
        .region (region),
        .addr   (bus_addr),
        .page   (page),
        .map    (map),
        .cmn_kb (cmn_kb),
        .phys   (phys_addr)
    );

    // R2
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> $countones({sel_fixed, sel_rom, sel_ram}) == 1);
    // R2
    idle_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> $countones({sel_fixed, sel_rom, sel_ram}) == 0);
    // R9
    vector_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[LA_W-1:4] == 12'hFFF) |-> (sel_fixed && phys_addr[LA_W-1:0] == bus_addr));
    // R8
    reg_overlay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr >= PAGE_REG_BASE && bus_addr <= MAP_REG_BASE + 16'd3) |-> sel_ram);
endmodule

// File: tb/bank_xlate_test.sv
module bank_xlate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [18:0] phys_addr;
    logic        sel_fixed, sel_rom, sel_ram;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference state
    int m_page = 0;
    int m_map = 0;
    int m_cmn = 0;

    bank_xlate uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .phys_addr (phys_addr),
        .sel_fixed (sel_fixed),
        .sel_rom   (sel_rom),
        .sel_ram   (sel_ram)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare the outputs with the reference model for the current inputs
    task automatic compare(input string req);
        int a, exp_phys, ef, eo, er, map_used;
        a = int'(bus_addr);
        ef = 0; eo = 0; er = 0; exp_phys = 0;
        if (a >= 'hA000) begin
            ef = 1; exp_phys = 'h70000 + a;
        end else if (a >= 'h8000) begin
            eo = 1; exp_phys = 'h40000 + m_page * 8192 + (a - 'h8000);
        end else begin
            er = 1;
            map_used = ((a / 1024) < m_cmn) ? 0 : m_map;
            exp_phys = map_used * 32768 + a;
        end
        if (!bus_valid) begin ef = 0; eo = 0; er = 0; end
        checks++;
        if ((bus_valid && int'(phys_addr) != exp_phys) || int'(sel_fixed) != ef ||
            int'(sel_rom) != eo || int'(sel_ram) != er) begin
            fails++;
            $display("FAIL %s addr=%h: got phys=%h sel f/o/r=%0d%0d%0d, expected phys=%h sel f/o/r=%0d%0d%0d",
                     req, bus_addr, phys_addr, sel_fixed, sel_rom, sel_ram,
                     exp_phys[18:0], ef, eo, er);
        end
    endtask

    // One bus cycle: drive, check mid-cycle, then let the edge update state
    task automatic cyc(input logic [15:0] a, input logic [7:0] d,
                       input logic we, input logic v, input string req);
        bus_addr = a; bus_wdata = d; bus_we = we; bus_valid = v;
        @(negedge clk);
        compare(req);
        @(posedge clk);
        if (v && we) begin
            if (a >= 16'h0004 && a <= 16'h0007) m_page = int'(d) & 15;
            if (a >= 16'h0008 && a <= 16'h000B) begin
                m_map = int'(d) & 7;
                m_cmn = (int'(d) >> 4) & 7;
            end
        end
        #1;
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        cyc(a, 8'h00, 1'b0, 1'b1, req);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
        cyc(a, d, 1'b1, 1'b1, req);
    endtask

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state seen through translation
        rd(16'h8000, "R1");
        rd(16'h1234, "R1");
        // R2: all selects low when idle
        cyc(16'h8000, 8'h00, 1'b0, 1'b0, "R2");
        // R2 R3: boundaries and fixed pass-through
        rd(16'h7FFF, "R2");
        rd(16'h0000, "R2");
        rd(16'h9FFF, "R2");
        rd(16'hA000, "R3");
        rd(16'hC123, "R3");
        rd(16'hFFFF, "R3");
        // R4: page select
        wr(16'h0005, 8'h0B, "R8");
        rd(16'h9ABC, "R4");
        rd(16'h8000, "R4");
        // R5 R7: map select leaves page alone
        wr(16'h000A, 8'h05, "R8");
        rd(16'h1234, "R5");
        rd(16'h8123, "R7");
        // R6: common area 3 KB with map 3
        wr(16'h0009, 8'h33, "R8");
        rd(16'h0BFF, "R6");
        rd(16'h0C00, "R6");
        rd(16'h7FFF, "R5");
        // R7: page write leaves map and common size alone
        wr(16'h0006, 8'h02, "R8");
        rd(16'h0C00, "R7");
        rd(16'h0BFF, "R7");
        rd(16'h8001, "R4");
        // R8: read of register address is a RAM read, no register change
        cyc(16'h0004, 8'hFF, 1'b0, 1'b1, "R8");
        rd(16'h9000, "R10");
        // R10: writes outside the register block and idle writes
        wr(16'h0003, 8'hFF, "R10");
        wr(16'h000C, 8'hFF, "R10");
        cyc(16'h0007, 8'h0F, 1'b1, 1'b0, "R10");
        cyc(16'h000B, 8'h77, 1'b1, 1'b0, "R10");
        rd(16'h9000, "R10");
        rd(16'h2000, "R10");
        rd(16'h0400, "R10");
        // R9: vectors under several settings
        rd(16'hFFF8, "R9");
        wr(16'h0008, 8'h77, "R8");
        rd(16'hFFFE, "R9");
        rd(16'hFFF0, "R9");
        // R6: common area 7 KB
        rd(16'h1BFF, "R6");
        rd(16'h1C00, "R6");
        rd(16'h0000, "R6");
        // R4: upper write data bits ignored
        wr(16'h0007, 8'hF0, "R4");
        rd(16'h9FFF, "R4");
        // R4: every page
        for (int p = 0; p < 16; p++) begin
            wr(16'h0004 + 16'(p % 4), 8'(p), "R4");
            rd(16'h8000 + 16'(p * 37), "R4");
        end
        // R5: every map, common size 0
        for (int m = 0; m < 8; m++) begin
            wr(16'h0008 + 16'(m % 4), 8'(m), "R5");
            rd(16'h0000 + 16'(m * 4099), "R5");
            rd(16'h7FFF, "R5");
        end
        // R9 R2: vector after all changes
        rd(16'hFFFF, "R9");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule